// File: doc/BRIEF.md
# H-Bridge Direction, Brake and Sense-Select Decoder

This block turns the control inputs of a full-bridge motor driver into the four gate enables of the bridge and a code that picks what the current-sense output reports. The inputs are two direction levels, one sense-select level and one speed-modulation level. The enables are high-side and low-side for leg A and for leg B. The decode is combinational, so a gate follows its inputs within the same cycle. The modulation level drives only the low-side switches. Each enable passes through a per-switch inhibit that the fault logic drives.

When all four control inputs stay low for a programmable number of cycles, the block enters a low-power standby. In standby every enable is off and the sense output is high impedance. When any input rises, the block leaves standby on the next clock edge. After that exit, a wake-up sequencer keeps the low-side switches off for a fixed number of cycles. This lets the host raise a direction level first and start modulating only after a safe delay.

Top module: `hbridge_ctrl`

## Requirements
- R1: After reset, `standby` is low, the wake-up hold is inactive, and with all inputs low all four gate enables are off.
- R2: With `dir_a`=1 and `dir_b`=1, both high-side enables are on and both low-side enables are off, whatever the level of `pwm`.
- R3: With `dir_a`=1 and `dir_b`=0, high-side A is on and low-side B equals `pwm`. High-side B and low-side A are off.
- R4: With `dir_a`=0 and `dir_b`=1, high-side B is on and low-side A equals `pwm`. High-side A and low-side B are off.
- R5: With `dir_a`=0 and `dir_b`=0, both high-side enables are off and both low-side enables equal `pwm`.
- R6: While `pwm` is low, both low-side enables are off in every input state.
- R7: `sense_sel` encoding: 2'b00 is high impedance, 2'b01 monitors leg A, 2'b10 monitors leg B. The mapping is: both directions high with `sense_en`=1 gives leg A and with `sense_en`=0 gives leg B; `dir_a` only with `sense_en`=1 gives leg A, otherwise high impedance; `dir_b` only with `sense_en`=0 gives leg B, otherwise high impedance; both directions low gives high impedance.
- R8: `gate_en` bit order is 0 high-side A, 1 low-side A, 2 high-side B, 3 low-side B. When `inhibit[i]` is high, `gate_en[i]` is off in the same cycle, and the other bits are unaffected.
- R9: `standby` rises on the clock edge that samples all four inputs low for the L-th consecutive time, where L is the effective blanking length. While `standby` is high, `gate_en` is 0 and `sense_sel` is 2'b00.
- R10: Any input sampled high before the count completes restarts the count from zero.
- R11: The effective blanking length is `blank_len` clamped to the range [BLANK_MIN, BLANK_MAX] (defaults 4 and 36).
- R12: `standby` falls on the first edge that samples any input high. For the next WAKE_CYC cycles (default 5), both low-side enables are held off while the high-side enables follow the decode.
- R13: The high-side and low-side enables of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_a | input | 1 | Direction level for leg A |
| dir_b | input | 1 | Direction level for leg B |
| sense_en | input | 1 | Sense-select level |
| pwm | input | 1 | Speed-modulation level; gates the low-side switches |
| inhibit | input | 4 | Per-switch fault masks, same bit order as `gate_en` |
| blank_len | input | CNT_W (8) | Requested idle cycles before standby |
| gate_en | output | 4 | Gate enables: hs A, ls A, hs B, ls B |
| sense_sel | output | 2 | Sense multiplexer code |
| standby | output | 1 | Low-power standby state |

## Verification
The hardest situation to reach from the ports is the wake-up window. A test can only get there by holding every input low for the whole blanking count, then raising a direction level and `pwm` together. Only then can it be observed that the low-side enable stays off for exactly the hold length while the high-side enable is already on. The bench drives long idle stretches at several blanking lengths, including values below and above the clamp limits. It also interrupts a count one cycle before it completes. A behavioural model tracks the idle run and the wake countdown, so every cycle of these sequences is compared, not just their end points.

// File: rtl/hb_pkg.sv
package hb_pkg;
   localparam int NUM_SW = 4;
   localparam int SW_HS_A = 0;
   localparam int SW_LS_A = 1;
   localparam int SW_HS_B = 2;
   localparam int SW_LS_B = 3;

   typedef enum logic [1:0] {
      SENSE_HIZ   = 2'b00,
      SENSE_LEG_A = 2'b01,
      SENSE_LEG_B = 2'b10
   } sense_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
   import hb_pkg::*;
(
   input  logic              active,
   input  logic              dir_a,
   input  logic              dir_b,
   input  logic              sense_en,
   input  logic              pwm_ok,
   output logic [NUM_SW-1:0] raw_gate,
   output sense_e            sense
);
   always_comb begin
      raw_gate = '0;
      sense    = SENSE_HIZ;
      if (active) begin
         unique case ({dir_a, dir_b})
            2'b11: begin  // R2 brake to supply
               raw_gate[SW_HS_A] = 1'b1;
               raw_gate[SW_HS_B] = 1'b1;
               sense = sense_en ? SENSE_LEG_A : SENSE_LEG_B;
            end
            2'b10: begin  // R3
               raw_gate[SW_HS_A] = 1'b1;
               raw_gate[SW_LS_B] = pwm_ok;
               sense = sense_en ? SENSE_LEG_A : SENSE_HIZ;
            end
            2'b01: begin  // R4
               raw_gate[SW_HS_B] = 1'b1;
               raw_gate[SW_LS_A] = pwm_ok;
               sense = sense_en ? SENSE_HIZ : SENSE_LEG_B;
            end
            default: begin  // R5 brake to ground
               raw_gate[SW_LS_A] = pwm_ok;
               raw_gate[SW_LS_B] = pwm_ok;
               sense = SENSE_HIZ;
            end
         endcase
      end
   end
endmodule

// File: rtl/hb_idle_timer.sv
module hb_idle_timer #(
   parameter int CNT_W     = 8,
   parameter int BLANK_MIN = 4,
   parameter int BLANK_MAX = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic [CNT_W-1:0] blank_len,
   output logic             standby,
   output logic             wake_start
);
   localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(BLANK_MIN);
   localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(BLANK_MAX);

   generate
      if (BLANK_MIN < 1) begin : g_bad_min
         $error("BLANK_MIN must be at least 1");
      end
      if (BLANK_MAX < BLANK_MIN) begin : g_bad_range
         $error("BLANK_MAX must not be below BLANK_MIN");
      end
      if (BLANK_MAX >= (1 << CNT_W)) begin : g_bad_width
         $error("BLANK_MAX does not fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] run_cnt;
   logic             sb_q;

   // R11 clamp of the requested length
   always_comb begin
      if (blank_len < LIM_LO)      limit = LIM_LO;
      else if (blank_len > LIM_HI) limit = LIM_HI;
      else                         limit = blank_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sb_q    <= 1'b0;
         run_cnt <= '0;
      end else if (sb_q) begin
         run_cnt <= '0;
         if (!idle) sb_q <= 1'b0;        // R12 exit
      end else if (!idle) begin
         run_cnt <= '0;                  // R10 restart
      end else if (run_cnt == limit - 1'b1) begin
         sb_q    <= 1'b1;                // R9 entry
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   assign standby    = sb_q;
   assign wake_start = sb_q & ~idle;

   assert_entry_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sb_q) |-> $past(idle));
   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt < LIM_HI);
endmodule

// File: rtl/hb_wake_seq.sv
module hb_wake_seq #(
   parameter int WAKE_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (WAKE_CYC < 0) begin : g_bad_wake
         $error("WAKE_CYC must not be negative");
      end
      if (WAKE_CYC == 0) begin : g_no_hold
         assign busy = 1'b0;
      end else begin : g_hold
         localparam int W_W = $clog2(WAKE_CYC + 1);
         localparam logic [W_W-1:0] W_LOAD = W_W'(WAKE_CYC);
         logic [W_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (start)      cnt <= W_LOAD;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);

         assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
      end
   endgenerate
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
   import hb_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int BLANK_MIN = 4,
   parameter int BLANK_MAX = 36,
   parameter int WAKE_CYC  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_a,
   input  logic             dir_b,
   input  logic             sense_en,
   input  logic             pwm,
   input  logic [3:0]       inhibit,
   input  logic [CNT_W-1:0] blank_len,
   output logic [3:0]       gate_en,
   output logic [1:0]       sense_sel,
   output logic             standby
);
   logic              idle;
   logic              sb;
   logic              wake_start;
   logic              wake_busy;
   logic              pwm_ok;
   logic [NUM_SW-1:0] raw_gate;
   sense_e            sense;

   assign idle = ~(dir_a | dir_b | sense_en | pwm);

   hb_idle_timer #(
      .CNT_W    (CNT_W),
      .BLANK_MIN(BLANK_MIN),
      .BLANK_MAX(BLANK_MAX)
   ) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .blank_len (blank_len),
      .standby   (sb),
      .wake_start(wake_start)
   );

   hb_wake_seq #(.WAKE_CYC(WAKE_CYC)) u_wake (
      .clk  (clk),
      .rst_n(rst_n),
      .start(wake_start),
      .busy (wake_busy)
   );

   // R6, R12: modulation reaches the low side only when awake and settled
   assign pwm_ok = pwm & ~wake_busy & ~sb;

   hb_decode u_dec (
      .active  (~sb),
      .dir_a   (dir_a),
      .dir_b   (dir_b),
      .sense_en(sense_en),
      .pwm_ok  (pwm_ok),
      .raw_gate(raw_gate),
      .sense   (sense)
   );

   // R8: per-switch fault mask after decode
   generate
      for (genvar i = 0; i < NUM_SW; i++) begin : g_mask
         assign gate_en[i] = raw_gate[i] & ~inhibit[i];
         assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            inhibit[i] |-> !gate_en[i]);
      end
   endgenerate

   assign sense_sel = sense;
   assign standby   = sb;

   assert_leg_a_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_en[SW_HS_A] && gate_en[SW_LS_A]));
   assert_leg_b_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_en[SW_HS_B] && gate_en[SW_LS_B]));
   assert_pwm_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm |-> !(gate_en[SW_LS_A] || gate_en[SW_LS_B]));
   assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (gate_en == 4'b0000 && sense_sel == 2'b00));
   assert_wake_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wake_busy |-> !(gate_en[SW_LS_A] || gate_en[SW_LS_B]));
endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;
   localparam int CNT_W = 8;
   localparam int BMIN  = 4;
   localparam int BMAX  = 36;
   localparam int WAKE  = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             dir_a = 0, dir_b = 0, sense_en = 0, pwm = 0;
   logic [3:0]       inhibit = 4'h0;
   logic [CNT_W-1:0] blank_len = 8'd10;
   logic [3:0]       gate_en;
   logic [1:0]       sense_sel;
   logic             standby;

   hbridge_ctrl #(.CNT_W(CNT_W), .BLANK_MIN(BMIN), .BLANK_MAX(BMAX), .WAKE_CYC(WAKE)) u_dut (
      .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .sense_en(sense_en),
      .pwm(pwm), .inhibit(inhibit), .blank_len(blank_len),
      .gate_en(gate_en), .sense_sel(sense_sel), .standby(standby)
   );

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference state
   bit m_sb;
   int m_run;
   int m_wake;

   function automatic int eff_len(int v);
      if (v < BMIN) return BMIN;
      if (v > BMAX) return BMAX;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sb = 0; m_run = 0; m_wake = 0;
      end else begin
         bit idl;
         idl = !(dir_a || dir_b || sense_en || pwm);
         if (m_wake > 0) m_wake--;
         if (m_sb) begin
            m_run = 0;
            if (!idl) begin m_sb = 0; m_wake = WAKE; end
         end else if (idl) begin
            m_run++;
            if (m_run == eff_len(int'(blank_len))) begin m_sb = 1; m_run = 0; end
         end else begin
            m_run = 0;
         end
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] eg;
         logic [1:0] es;
         bit         pe;
         eg = 4'b0; es = 2'b00;
         pe = pwm && (m_wake == 0) && !m_sb;
         if (!m_sb) begin
            if (dir_a && dir_b) begin
               eg[0] = 1; eg[2] = 1; es = sense_en ? 2'b01 : 2'b10;
            end else if (dir_a) begin
               eg[0] = 1; eg[3] = pe; es = sense_en ? 2'b01 : 2'b00;
            end else if (dir_b) begin
               eg[2] = 1; eg[1] = pe; es = sense_en ? 2'b00 : 2'b10;
            end else begin
               eg[1] = pe; eg[3] = pe;
            end
         end
         eg = eg & ~inhibit;
         chk(gate_en == eg, {cur_req, " gates"}, gate_en, eg);
         chk(sense_sel == es, {cur_req, " sense"}, sense_sel, es);
         chk(standby == m_sb, {cur_req, " standby"}, standby, m_sb);
      end
   end

   task automatic drive(bit a, bit b, bit s, bit p);
      @(posedge clk); #2;
      dir_a = a; dir_b = b; sense_en = s; pwm = p;
   endtask

   task automatic standby_entry(int req_len, string tag);
      int L;
      L = eff_len(req_len);
      blank_len = CNT_W'(req_len);
      drive(1, 0, 0, 0);
      drive(0, 0, 0, 0);
      repeat (L - 1) @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b0, {tag, " standby early"}, standby, 0);
      @(posedge clk); @(negedge clk);
      chk(standby == 1'b1, {tag, " standby at length"}, standby, 1);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(standby == 1'b0, "R1 reset standby", standby, 0);
      chk(gate_en == 4'b0, "R1 reset gates", gate_en, 0);

      // R2 brake to supply, both pwm levels and select levels
      cur_req = "R2";
      drive(1, 1, 0, 0); drive(1, 1, 0, 1); drive(1, 1, 1, 1); drive(1, 1, 1, 0);
      @(negedge clk);
      chk(gate_en == 4'b0101, "R2 hs both on", gate_en, 4'b0101);
      chk(sense_sel == 2'b01, "R7 both high sel=1 leg A", sense_sel, 1);

      cur_req = "R3";
      drive(1, 0, 1, 1);
      @(negedge clk);
      chk(gate_en == 4'b1001, "R3 hs_a + ls_b", gate_en, 4'b1001);
      drive(1, 0, 0, 0);
      @(negedge clk);
      chk(gate_en == 4'b0001, "R6 pwm low ls off", gate_en, 4'b0001);
      chk(sense_sel == 2'b00, "R7 dir_a sel=0 hiz", sense_sel, 0);

      cur_req = "R4";
      drive(0, 1, 0, 1);
      @(negedge clk);
      chk(gate_en == 4'b0110, "R4 hs_b + ls_a", gate_en, 4'b0110);
      chk(sense_sel == 2'b10, "R7 dir_b sel=0 leg B", sense_sel, 2);

      cur_req = "R5";
      drive(0, 0, 1, 1);
      @(negedge clk);
      chk(gate_en == 4'b1010, "R5 brake to ground", gate_en, 4'b1010);

      // all input combinations
      cur_req = "R7";
      for (int c = 1; c < 16; c++) drive(c[3], c[2], c[1], c[0]);

      // inhibit masks over active states
      cur_req = "R8";
      for (int m = 0; m < 16; m++) begin
         inhibit = 4'(m);
         drive(1, 0, 1, 1);
         drive(0, 1, 0, 1);
         drive(1, 1, 1, 1);
         drive(0, 0, 0, 1);
      end
      drive(1, 0, 1, 1);
      inhibit = 4'b1000;
      @(negedge clk);
      chk(gate_en == 4'b0001, "R8 ls_b masked only", gate_en, 4'b0001);
      inhibit = 4'h0;

      // standby entry at nominal length
      cur_req = "R9";
      standby_entry(10, "R9");
      drive(0, 0, 0, 0);
      @(negedge clk);
      chk(gate_en == 4'b0 && sense_sel == 2'b0, "R9 quiet in standby", {gate_en, sense_sel}, 0);

      // wake-up hold
      cur_req = "R12";
      drive(1, 0, 1, 1);
      @(negedge clk);
      chk(gate_en == 4'b0000, "R12 gates off before exit edge", gate_en, 0);
      @(posedge clk); @(negedge clk);
      chk(standby == 1'b0, "R12 standby exit", standby, 0);
      chk(gate_en == 4'b0001, "R12 ls held off", gate_en, 4'b0001);
      repeat (WAKE - 1) @(posedge clk);
      @(negedge clk);
      chk(gate_en == 4'b0001, "R12 ls held off last cycle", gate_en, 4'b0001);
      @(posedge clk); @(negedge clk);
      chk(gate_en == 4'b1001, "R12 ls released", gate_en, 4'b1001);

      // restart of the count
      cur_req = "R10";
      blank_len = 8'd10;
      drive(0, 0, 0, 0);
      repeat (8) @(posedge clk);
      drive(0, 0, 1, 0);
      drive(0, 0, 0, 0);
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b0, "R10 count restarted", standby, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(standby == 1'b1, "R10 standby after full run", standby, 1);

      // clamp limits
      cur_req = "R11";
      standby_entry(1, "R11 low clamp");
      standby_entry(0, "R11 zero clamp");
      standby_entry(200, "R11 high clamp");
      standby_entry(BMAX, "R11 at max");

      // exit through pwm alone, then release
      cur_req = "R12";
      drive(0, 0, 0, 1);
      repeat (WAKE + 3) @(posedge clk);
      drive(0, 0, 0, 0);
      repeat (12) @(posedge clk);

      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule